// File: doc/BRIEF.md
# Video Load Strobe and Programmable Clock Generator

This block takes one fast pixel clock and derives the slower clocks that a video output path needs from it. The first is a load strobe whose division ratio follows the selected pixel multiplex rate (8:1, 4:1 or 2:1). The load strobe latches wide words of pixel data into the serializer. The second is a programmable clock, divided by 4, 8, 16 or 32. It can serve as the master clock of an attached graphics controller. Both are produced from one free-running phase counter, so their rising edges coincide.

A third path gates an incoming video-memory shift clock with the active-low blanking input. It registers the result on the pixel clock, so the shift clock stops while the display is blanked. The block samples a new setting on either select field only at the wrap of the 32-cycle phase counter. Because of this, neither divided clock ever produces a shortened pulse.

Top module: `vid_clock_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three outputs are low after that edge. On the first edge after `rst_n` returns high, `load_strobe` and `prog_clk` both go high.
- R2: `load_strobe` has period M pixel clocks with 50% duty cycle: high for the first M/2 cycles of each period, then low. The `mux_rate` encoding is 2'b00 → M=8, 2'b01 → M=4, 2'b10 → M=2 and 2'b11 → M=8.
- R3: `prog_clk` has period N pixel clocks with 50% duty cycle: high for the first N/2 cycles of each period. The `div_sel` encoding is 2'b00 → N=4, 2'b01 → N=8, 2'b10 → N=16 and 2'b11 → N=32. N is independent of `mux_rate`.
- R4: When N ≥ M, every rising edge of `prog_clk` falls on the same cycle as a rising edge of `load_strobe`. When N < M, every rising edge of `load_strobe` falls on the same cycle as a rising edge of `prog_clk`.
- R5: Counting the first cycle after reset release as cycle 0, a frame is 32 cycles long. The block samples `mux_rate` and `div_sel` only at the edge that starts each frame, at cycles 0, 32, 64 and so on. A change made at any other time has no effect until the next frame start.
- R6: `shift_clk_out` equals `shift_clk_in` AND `blank_n`, as sampled at the previous rising pixel-clock edge.
- R7: While `blank_n` is low at an edge, `shift_clk_out` is low after that edge, whatever the value of `shift_clk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_rate | input | 2 | Pixel multiplex rate select; sets load divider M |
| div_sel | input | 2 | Programmable clock divider select; sets N |
| shift_clk_in | input | 1 | Incoming video-memory shift clock |
| blank_n | input | 1 | Blanking, active low |
| load_strobe | output | 1 | Pixel load strobe, clk/M |
| prog_clk | output | 1 | Programmable clock, clk/N |
| shift_clk_out | output | 1 | Blank-gated, registered shift clock |

## Verification
Two events can fall in the same cycle: a select change and the frame-start edge, where both divided clocks rise together. The bench provokes this by driving new values on `mux_rate` and `div_sel` exactly one cycle before the frame start. It also drives changes at cycles in mid-frame and toggles `blank_n` throughout. A scoreboard model built from the requirements predicts every output on every cycle. The model checks that the new ratios take effect on that frame-start edge and not before, and that the edges of the two clocks stay aligned across the change.

// File: rtl/vcg_pkg.sv
// Package: shared widths and select decoding for the video clock generator.
// Assumes the largest division ratio is 2**CNT_W and the smallest is 2.
package vcg_pkg;
    localparam int CNT_W = 5;
    localparam int LG_W  = 3;
    localparam int DIV_LG_BASE = 2;

    typedef logic [LG_W-1:0] lg_t;

    typedef enum logic [1:0] {
        MUX_8TO1 = 2'b00,
        MUX_4TO1 = 2'b01,
        MUX_2TO1 = 2'b10,
        MUX_ALT8 = 2'b11
    } mux_rate_e;

    // Decode the multiplex rate into log2 of the load divider.
    function automatic lg_t mux_to_lg(input logic [1:0] sel);
        case (mux_rate_e'(sel))
            MUX_4TO1: return lg_t'(2);
            MUX_2TO1: return lg_t'(1);
            default:  return lg_t'(3);
        endcase
    endfunction

    // Decode the divider select into log2 of the programmable divider.
    function automatic lg_t div_to_lg(input logic [1:0] sel);
        return lg_t'(sel) + lg_t'(DIV_LG_BASE);
    endfunction
endpackage

// File: rtl/vcg_phase_counter.sv
// Free-running phase counter shared by all divided outputs.
// Assumes: reset loads all ones so the first post-reset edge lands on phase 0.
module vcg_phase_counter #(
    parameter int W = vcg_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         wrap_nxt
);
    // Next phase value and frame-start flag.
    always_comb begin
        cnt_nxt  = cnt_q + W'(1);
        wrap_nxt = (cnt_nxt == '0);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/vcg_rate_divider.sv
// Power-of-two divider: produces a 50% duty clock of period 2**lg from the
// shared phase. A requested ratio is adopted only at the frame start.
// Assumes: requested lg is between 1 and W.
module vcg_rate_divider #(
    parameter int W    = vcg_pkg::CNT_W,
    parameter int LG_W = vcg_pkg::LG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    cnt_q,
    input  logic [W-1:0]    cnt_nxt,
    input  logic            wrap_nxt,
    input  logic [LG_W-1:0] req_lg,
    output logic            div_out,
    output logic [LG_W-1:0] lg_q
);
    logic [LG_W-1:0] eff_lg;
    logic [W-1:0]    cur_mask;

    // Ratio in force for the coming cycle.
    always_comb begin
        eff_lg   = wrap_nxt ? req_lg : lg_q;
        cur_mask = (W'(1) << lg_q) - W'(1);
    end

    // Output phase and adopted ratio registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_out <= 1'b0;
            lg_q    <= LG_W'(1);
        end else begin
            div_out <= ~cnt_nxt[eff_lg - LG_W'(1)];
            lg_q    <= eff_lg;
        end
    end

    // R2/R3: a rising edge only at the start of the own period.
    assert_rise_on_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> ((cnt_q & cur_mask) == '0));

    // R5: the adopted ratio only changes on the frame-start cycle.
    assert_ratio_at_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(lg_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/vcg_shift_gate.sv
// Registered AND of the shift clock with active-low blanking.
// Assumes both inputs are synchronous to the pixel clock.
module vcg_shift_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic blank_n,
    output logic sck_out
);
    // Sampling stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_out <= 1'b0;
        else        sck_out <= sck_in & blank_n;
    end

    // R7: blanking forces the output low.
    assert_blank_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(blank_n)) |-> !sck_out);

    // R6: a low shift clock input yields a low output.
    assert_low_input_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sck_in)) |-> !sck_out);
endmodule

// File: rtl/vid_clock_gen.sv
// Top: load strobe (clk/M), programmable clock (clk/N) and blank-gated
// shift clock. Both dividers share one phase counter, so edges align.
// Assumes selects are synchronous to clk.
module vid_clock_gen #(
    parameter int CNT_W = vcg_pkg::CNT_W,
    parameter int LG_W  = vcg_pkg::LG_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mux_rate,
    input  logic [1:0] div_sel,
    input  logic       shift_clk_in,
    input  logic       blank_n,
    output logic       load_strobe,
    output logic       prog_clk,
    output logic       shift_clk_out
);
    localparam int NUM_DIV = 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap_nxt;
    logic [LG_W-1:0]  req_lg [NUM_DIV];
    logic [LG_W-1:0]  act_lg [NUM_DIV];
    logic [NUM_DIV-1:0] div_clk;

    // Decode the select fields into requested log2 ratios.
    always_comb begin
        req_lg[0] = vcg_pkg::mux_to_lg(mux_rate);
        req_lg[1] = vcg_pkg::div_to_lg(div_sel);
    end

    vcg_phase_counter #(.W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap_nxt(wrap_nxt)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        vcg_rate_divider #(.W(CNT_W), .LG_W(LG_W)) u_div (
            .clk(clk), .rst_n(rst_n),
            .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap_nxt(wrap_nxt),
            .req_lg(req_lg[g]),
            .div_out(div_clk[g]), .lg_q(act_lg[g])
        );
    end

    vcg_shift_gate u_gate (
        .clk(clk), .rst_n(rst_n),
        .sck_in(shift_clk_in), .blank_n(blank_n), .sck_out(shift_clk_out)
    );

    // Output naming.
    always_comb begin
        load_strobe = div_clk[0];
        prog_clk    = div_clk[1];
    end

    // R1: reset clears every output.
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (!load_strobe && !prog_clk && !shift_clk_out));

    // R4: the slower clock rises only together with the faster one.
    assert_prog_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(prog_clk) && (act_lg[1] >= act_lg[0])) |-> $rose(load_strobe));
    assert_load_on_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(load_strobe) && (act_lg[1] < act_lg[0])) |-> $rose(prog_clk));
endmodule

// File: tb/vid_clock_gen_tb.sv
module vid_clock_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME = 32;
    localparam int WATCHDOG_CYCLES = 200000;

    typedef struct {
        logic load;
        logic prog;
        logic sck;
        int   m;
        int   n;
        logic rst;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mux_rate = 2'b00;
    logic [1:0] div_sel = 2'b00;
    logic shift_clk_in = 1'b0;
    logic blank_n = 1'b1;
    logic load_strobe, prog_clk, shift_clk_out;

    int errors = 0;
    int checks = 0;
    int k = 0;
    logic [1:0] am = 2'b00;
    logic [1:0] an = 2'b00;
    logic prev_load = 1'b0;
    logic prev_prog = 1'b0;
    bit done = 0;
    exp_t exp_q[$];

    vid_clock_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mux_rate(mux_rate), .div_sel(div_sel),
        .shift_clk_in(shift_clk_in), .blank_n(blank_n),
        .load_strobe(load_strobe), .prog_clk(prog_clk), .shift_clk_out(shift_clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int m_of(input logic [1:0] s);
        case (s)
            2'b01: return 4;
            2'b10: return 2;
            default: return 8;
        endcase
    endfunction

    // Driver: apply inputs at a falling edge and predict the next edge's outputs.
    task automatic step(input logic r, input logic [1:0] mx, input logic [1:0] dv,
                        input logic si, input logic bn);
        exp_t e;
        rst_n = r; mux_rate = mx; div_sel = dv; shift_clk_in = si; blank_n = bn;
        e.rst = !r;
        if (!r) begin
            e.load = 0; e.prog = 0; e.sck = 0; e.m = 8; e.n = 4; k = 0;
        end else begin
            if (k % FRAME == 0) begin am = mx; an = dv; end
            e.m = m_of(am);
            e.n = 4 << an;
            e.load = (k % e.m) < (e.m / 2);
            e.prog = (k % e.n) < (e.n / 2);
            e.sck = si & bn;
            k++;
        end
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic check(input logic act, input logic expv, input string req, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, expv, $time);
        end
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.rst) begin
                    check(load_strobe, 1'b0, "R1", "load in reset");
                    check(prog_clk, 1'b0, "R1", "prog in reset");
                    check(shift_clk_out, 1'b0, "R1", "sck in reset");
                end else begin
                    check(load_strobe, e.load, "R2", "load_strobe");
                    check(prog_clk, e.prog, "R3", "prog_clk");
                    check(shift_clk_out, e.sck, e.sck ? "R6" : "R7", "shift_clk_out");
                    // R4: the slower clock rises together with the faster one
                    if (e.n >= e.m && prog_clk && !prev_prog)
                        check(load_strobe && !prev_load, 1'b1, "R4", "load rise with prog rise");
                    if (e.n < e.m && load_strobe && !prev_load)
                        check(prog_clk && !prev_prog, 1'b1, "R4", "prog rise with load rise");
                end
                prev_load = load_strobe;
                prev_prog = prog_clk;
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset held for a few cycles
        repeat (3) step(0, 2'b00, 2'b00, 1'b1, 1'b1);
        // R2/R3: sweep every mux/divider pairing, two frames each, with
        // the change landing right before a frame start (R5 boundary)
        for (int mx = 0; mx < 4; mx++) begin
            for (int dv = 0; dv < 4; dv++) begin
                for (int c = 0; c < 2 * FRAME; c++) begin
                    logic [1:0] smx, sdv;
                    smx = (c == 2 * FRAME - 1) ? 2'((mx + 1) % 4) : 2'(mx);
                    sdv = (c == 2 * FRAME - 1) ? 2'((dv + 1) % 4) : 2'(dv);
                    step(1, smx, sdv, c[0], !(c % 7 == 3));
                end
            end
        end
        // R5: changes in mid-frame must wait for the next frame start
        for (int c = 0; c < 3 * FRAME; c++) begin
            logic [1:0] smx, sdv;
            smx = (c % 11 < 5) ? 2'b10 : 2'b01;
            sdv = (c % 13 < 6) ? 2'b11 : 2'b00;
            step(1, smx, sdv, c[1], c[2]);
        end
        // R7: blanking held low while shift clock toggles
        for (int c = 0; c < FRAME; c++) step(1, 2'b01, 2'b10, c[0], 1'b0);
        // R1: reset in mid-run, then restart with a fast pairing
        repeat (2) step(0, 2'b10, 2'b00, 1'b1, 1'b1);
        for (int c = 0; c < 2 * FRAME; c++) step(1, 2'b10, 2'b00, c[0], 1'b1);
        step(1, 2'b10, 2'b00, 1'b0, 1'b1);
        @(posedge clk); #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule